// File: doc/BRIEF.md
# Burst-Four Quad-Data-Rate SRAM Model

This block is a synthesizable model of a separate-I/O static RAM with a dedicated read data port and a dedicated write data port that share one address bus. It runs from one clock, `clk`, at the data beat rate: each rising edge of `clk` is one data beat, two edges make one memory clock period, and four edges make one frame. A frame holds one read address slot (frame edge 0) and one write address slot (frame edge 2). Each address names a location of four words. An accepted request moves all four words as a burst of four beats. A read and a write can run in the same frame without any bus turnaround.

The first rising edge after reset is released is frame edge 0. A write burst carries its four data beats on the edge where its address is taken and on the three edges after it. Each beat is masked per byte lane. A read takes a snapshot of its location at its address edge. The snapshot includes the last two beats of the write that is still in flight, so every read returns the data of all writes whose address was accepted before it, and nothing from later writes. The `lat_long` input selects where the read data appears: five edges after the address (two and a half memory cycles) or two edges after it (one memory cycle). `rd_valid` is high for exactly the four beats of each burst.

Top module: `qdr4_sram`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following outputs are `rd_valid`=0 and `rd_data`=0. Reads that were accepted before the reset produce no output afterwards.
- R2: Edges are counted from 0 at the first edge after reset is released. A read address is taken only when edge mod 4 = 0 and a write address only when edge mod 4 = 2. A select that is low on any other edge is ignored.
- R3: A write accepted at edge w stores the `wdata` beat present at edge w+k into word k (k = 0..3, linear order) of the location on `addr` at edge w.
- R4: `wbe` bit i enables byte lane i, which is `wdata[8i+7:8i]`, for the beat present at that edge. A lane whose bit is 0 keeps its stored byte.
- R5: With `lat_long`=1, a read accepted at edge r puts word k on `rd_data` after edge r+5+k, and `rd_valid` is high after exactly those four edges.
- R6: With `lat_long`=0, word k of a read accepted at edge r appears after edge r+2+k, and `rd_valid` is high after exactly those four edges.
- R7: When `rd_valid` is 0, `rd_data` is 0.
- R8: A read accepted two edges after a write to the same location returns all four words of that write, merged per lane with the old contents. This holds even though the write's last two beats have not yet reached the array.
- R9: A read accepted in the same frame as a write to the same location, and two edges before it, returns the data held before that write.
- R10: A port whose select is high at its slot starts no burst. Data beats and lane enables driven while no write burst is active leave the array unchanged, and no read output appears without an accepted read.
- R11: Reads accepted in consecutive frames give an unbroken run of valid beats, while writes run in the same frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock; two edges per memory clock period |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_long | input | 1 | 1: read latency of five edges; 0: two edges. Change only while no read is in flight |
| addr | input | ADDR_W (4) | Shared location address; read on frame edge 0, write on frame edge 2 |
| rd_sel_n | input | 1 | Active-low read select, sampled on frame edge 0 |
| wr_sel_n | input | 1 | Active-low write select, sampled on frame edge 2 |
| wdata | input | DATA_W (16) | Write data beat |
| wbe | input | DATA_W/8 (2) | Per-byte write enables for the current beat |
| rd_data | output | DATA_W (16) | Read data beat, zero when not valid |
| rd_valid | output | 1 | High while `rd_data` carries a burst word |

## Verification
A read accepted at edge r has its word k due after edge r+5+k in the long mode and after edge r+2+k in the short mode. The bench keeps a 16-entry ring of expected beats, indexed by edge number. When it issues a read, it writes the expected beats into the slots for those edges, using a reference copy of the array that already holds every write accepted earlier. It samples both outputs 1 ns after every rising edge. It compares each edge's outputs with that edge's slot and then clears the slot, so a beat that arrives early, arrives late or is missing is reported at the exact edge. Write beats, deselects and off-slot selects change the expected values only through the reference copy, and the reads that follow bring those effects out.

// File: rtl/qdr4_pkg.sv
// Shared constants for the burst-four SRAM model.
// Assumes the clock runs at the beat rate, so one memory cycle is two edges.
package qdr4_pkg;
    localparam int BURST     = 4;   // words per location, one per beat
    localparam int LONG_LAT  = 5;   // edges from read address to first word, long mode
    localparam int SHORT_LAT = 2;   // edges from read address to first word, short mode
    localparam int HIST      = LONG_LAT + BURST - 1;
    typedef logic [1:0] beat_t;
endpackage

// File: rtl/qdr4_slot_timer.sv
// Frame timer: counts beats modulo four and marks the read address slot
// (frame edge 0) and the write address slot (frame edge 2).
// Assumes the first edge after reset release is frame edge 0.
module qdr4_slot_timer
    import qdr4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic rd_slot,
    output logic wr_slot
);
    beat_t phase;

    // advance the beat position within the frame
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 2'd1;
    end

    assign rd_slot = (phase == 2'd0);
    assign wr_slot = (phase == 2'd2);
endmodule

// File: rtl/qdr4_write_path.sv
// Write sequencer: takes the write address at the write slot, then steers
// four consecutive data beats into words 0..3 of that location. It also
// reports the burst in flight so that reads can forward its late beats.
// Assumes write slots are four edges apart, so bursts never overlap.
module qdr4_write_path
    import qdr4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_slot,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_loc,
    output beat_t             mem_word,
    output logic              busy,
    output beat_t             cur_idx,
    output logic [ADDR_W-1:0] cur_loc
);
    logic              start;
    logic              act;
    beat_t             idx;
    logic [ADDR_W-1:0] loc;

    assign start = wr_slot && !wr_sel_n;

    // pick the array word written on this beat
    always_comb begin
        mem_we   = start || act;
        mem_loc  = start ? addr : loc;
        mem_word = start ? 2'd0 : idx;
    end

    // track the burst: location, next word, active flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
            idx <= '0;
            loc <= '0;
        end else if (start) begin
            act <= 1'b1;
            idx <= 2'd1;
            loc <= addr;
        end else if (act) begin
            idx <= idx + 2'd1;
            if (idx == 2'(BURST - 1)) act <= 1'b0;
        end
    end

    assign busy    = act;
    assign cur_idx = idx;
    assign cur_loc = loc;
endmodule

// File: rtl/qdr4_word_array.sv
// Storage: 2**ADDR_W locations of four words each, one masked word write per
// edge, and a combinational read of all four words of one location.
// Contents are not reset.
module qdr4_word_array
    import qdr4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       wloc,
    input  beat_t                   wword,
    input  logic [LANES-1:0]        wbe,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [ADDR_W-1:0]       rloc,
    output logic [BURST*DATA_W-1:0] rwords
);
    localparam int LANE_W = DATA_W / LANES;
    localparam int WORDS  = (2 ** ADDR_W) * BURST;

    logic [DATA_W-1:0] mem [WORDS];

    // masked write of one word per beat
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we && wbe[l])
                mem[{wloc, wword}][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        end
    end

    // expose the whole location for the read snapshot
    for (genvar k = 0; k < BURST; k++) begin : g_rd
        assign rwords[k*DATA_W +: DATA_W] = mem[{rloc, 2'(k)}];
    end
endmodule

// File: rtl/qdr4_read_path.sv
// Read sequencer: at the read slot, takes a snapshot of the addressed
// location into one of two burst buffers. The snapshot forwards beats 2 and 3
// of a write to the same location that is still in flight. A history shift
// register then sends the four words out at the selected latency.
// Assumes lat_long changes only while no read is in flight.
module qdr4_read_path
    import qdr4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_slot,
    input  logic                    rd_sel_n,
    input  logic                    lat_long,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BURST*DATA_W-1:0] arr_words,
    input  logic                    wr_busy,
    input  beat_t                   wr_idx,
    input  logic [ADDR_W-1:0]       wr_loc,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [LANES-1:0]        wbe,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_valid
);
    localparam int LANE_W = DATA_W / LANES;

    logic              cap;
    logic              hit2;
    logic              rptr;
    logic [1:0]        pend;
    logic [HIST-1:0]   hv;
    logic [HIST-1:0]   hb;
    logic [DATA_W-1:0] bufw [2][BURST];
    logic              sel_v;
    logic              sel_b;
    beat_t             sel_k;

    function automatic logic [DATA_W-1:0] lane_mix(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [LANES-1:0]  en);
        logic [DATA_W-1:0] r;
        r = old_w;
        for (int l = 0; l < LANES; l++)
            if (en[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
        return r;
    endfunction

    assign cap  = rd_slot && !rd_sel_n;
    assign hit2 = wr_busy && (wr_idx == 2'd2) && (wr_loc == addr);

    // buffer pointer and one-edge pending merge flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= 1'b0;
            pend <= '0;
        end else begin
            pend <= '0;
            if (cap) begin
                pend[rptr] <= hit2;
                rptr       <= ~rptr;
            end
        end
    end

    // snapshot and forwarding of in-flight write beats into the burst buffers
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int b = 0; b < 2; b++)
                if (pend[b] && wr_busy && wr_idx == 2'd3)
                    bufw[b][3] <= lane_mix(bufw[b][3], wdata, wbe);
            if (cap) begin
                for (int k = 0; k < BURST; k++)
                    bufw[rptr][k] <= arr_words[k*DATA_W +: DATA_W];
                if (hit2)
                    bufw[rptr][2] <= lane_mix(arr_words[2*DATA_W +: DATA_W], wdata, wbe);
            end
        end
    end

    // history of accepted reads and the buffer each one used
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hv <= '0;
            hb <= '0;
        end else begin
            hv <= {hv[HIST-2:0], cap};
            hb <= {hb[HIST-2:0], rptr};
        end
    end

    // find the burst word due on this edge
    always_comb begin
        sel_v = 1'b0;
        sel_b = 1'b0;
        sel_k = '0;
        for (int k = 0; k < BURST; k++) begin
            int h;
            h = (lat_long ? LONG_LAT : SHORT_LAT) - 1 + k;
            if (hv[h]) begin
                sel_v = 1'b1;
                sel_b = hb[h];
                sel_k = 2'(k);
            end
        end
    end

    // registered output beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= sel_v;
            rd_data  <= sel_v ? bufw[sel_b][sel_k] : '0;
        end
    end
endmodule

// File: rtl/qdr4_sram.sv
// Top level of the burst-four quad-data-rate SRAM model: frame timer, write
// sequencer, word array and read sequencer. The clock is the beat clock;
// reset is synchronous and active low and leaves the array contents undefined.
module qdr4_sram
    import qdr4_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_long,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wbe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic                    rd_slot, wr_slot;
    logic                    mem_we;
    logic [ADDR_W-1:0]       mem_loc;
    beat_t                   mem_word;
    logic                    wr_busy;
    beat_t                   wr_idx;
    logic [ADDR_W-1:0]       wr_loc;
    logic [BURST*DATA_W-1:0] arr_words;

    qdr4_slot_timer u_timer (
        .clk(clk), .rst_n(rst_n), .rd_slot(rd_slot), .wr_slot(wr_slot)
    );

    qdr4_write_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_slot(wr_slot), .wr_sel_n(wr_sel_n),
        .addr(addr), .mem_we(mem_we), .mem_loc(mem_loc), .mem_word(mem_word),
        .busy(wr_busy), .cur_idx(wr_idx), .cur_loc(wr_loc)
    );

    qdr4_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_arr (
        .clk(clk), .we(mem_we), .wloc(mem_loc), .wword(mem_word), .wbe(wbe),
        .wdata(wdata), .rloc(addr), .rwords(arr_words)
    );

    qdr4_read_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_slot(rd_slot), .rd_sel_n(rd_sel_n),
        .lat_long(lat_long), .addr(addr), .arr_words(arr_words),
        .wr_busy(wr_busy), .wr_idx(wr_idx), .wr_loc(wr_loc),
        .wdata(wdata), .wbe(wbe), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/qdr4_sram_chk.sv
// Port-level checker for qdr4_sram. It keeps its own frame counter from reset
// and checks output timing against the accepted reads.
module qdr4_sram_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lat_long,
    input logic              rd_sel_n,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);
    logic [1:0] ck_ph;
    logic [3:0] since;
    logic       ck_cap;

    assign ck_cap = (ck_ph == 2'd0) && !rd_sel_n;

    // independent beat position
    always_ff @(posedge clk) begin
        if (!rst_n) ck_ph <= '0;
        else        ck_ph <= ck_ph + 2'd1;
    end

    // edges since the most recent accepted read, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)           since <= 4'd15;
        else if (ck_cap)      since <= 4'd0;
        else if (since != 15) since <= since + 4'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && rd_data == '0));

    p_long_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_cap && lat_long) |-> ##6 rd_valid);

    p_short_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_cap && !lat_long) |-> ##3 rd_valid);

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);

    p_no_orphan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> since <= 4'd8);
endmodule

bind qdr4_sram qdr4_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lat_long(lat_long), .rd_sel_n(rd_sel_n),
    .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/qdr4_sram_tb.sv
`timescale 1ns/1ps
module qdr4_sram_tb;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int NL = 2;
    localparam int NLOC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lat_long = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic [NL-1:0] wbe = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int    total = 0;
    int    bad = 0;
    int    t = 0;
    string req = "R1";

    logic          exp_v [16];
    logic [DW-1:0] exp_d [16];
    logic [DW-1:0] ref_m [NLOC][4];
    logic [DW-1:0] pw_d [4];
    logic [NL-1:0] pw_be [4];

    always #2.5 clk = ~clk;

    qdr4_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lat_long(lat_long), .addr(addr),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .wdata(wdata), .wbe(wbe),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [DW-1:0] pat(int loc, int k, int seed);
        return DW'(loc * 1103 + k * 257 + seed * 4099 + 7);
    endfunction

    task automatic chk(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s edge=%0d actual=%h expected=%h", r, t, act, exp);
        end
    endtask

    // drive one beat, then check the outputs of that edge
    task automatic edge_go(logic rsn, logic wsn, logic [AW-1:0] a,
                           logic [DW-1:0] d, logic [NL-1:0] be);
        rd_sel_n = rsn; wr_sel_n = wsn; addr = a; wdata = d; wbe = be;
        @(posedge clk); #1;
        chk({req, " valid"}, DW'(rd_valid), DW'(exp_v[t % 16]));
        if (exp_v[t % 16]) chk({req, " data"}, rd_data, exp_d[t % 16]);
        else               chk("R7 idle data", rd_data, '0);
        exp_v[t % 16] = 1'b0;
        t++;
    endtask

    // one frame: optional read at edge 0, optional write at edge 2;
    // junk drives off-slot selects low
    task automatic frame(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                         int seed, logic [4*NL-1:0] bes, bit junk);
        int lat;
        lat = lat_long ? 5 : 2;
        if (rd) begin
            for (int k = 0; k < 4; k++) begin
                exp_v[(t + lat + k) % 16] = 1'b1;
                exp_d[(t + lat + k) % 16] = ref_m[ra][k];
            end
        end
        edge_go(!rd, !junk, ra, pw_d[2], pw_be[2]);
        edge_go(!junk, !junk, ~ra, pw_d[3], pw_be[3]);
        if (wr) begin
            for (int k = 0; k < 4; k++)
                for (int l = 0; l < NL; l++)
                    if (bes[k*NL + l]) ref_m[wa][k][l*8 +: 8] = pat(wa, k, seed)[l*8 +: 8];
            for (int k = 0; k < 4; k++) begin
                pw_d[k]  = pat(wa, k, seed);
                pw_be[k] = bes[k*NL +: NL];
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                pw_d[k]  = ~pat(wa, k, seed + 50);
                pw_be[k] = '1;
            end
        end
        edge_go(!junk, !wr, wa, pw_d[0], pw_be[0]);
        edge_go(!junk, !junk, ~wa, pw_d[1], pw_be[1]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rd_sel_n = 1'b1; wr_sel_n = 1'b1;
        repeat (3) begin
            @(posedge clk); #1;
            chk("R1 reset valid", DW'(rd_valid), '0);
            chk("R1 reset data", rd_data, '0);
        end
        rst_n = 1'b1;
        t = 0;
        for (int i = 0; i < 16; i++) exp_v[i] = 1'b0;
        for (int k = 0; k < 4; k++) begin pw_d[k] = '0; pw_be[k] = '0; end
    endtask

    task automatic drain();
        repeat (3) frame(0, '0, 0, '0, 9, '1, 1);
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_v[i] = 1'b0;
        do_reset();

        for (int mode = 1; mode >= 0; mode--) begin
            lat_long = mode[0];
            // R3: fill every location with full-lane bursts
            req = "R3";
            for (int loc = 0; loc < NLOC; loc++) frame(0, '0, 1, AW'(loc), 1 + mode, '1, 0);
            // R5 R6 R11 R2: back-to-back reads with off-slot selects held low
            req = mode ? "R5 R11 R2" : "R6 R11 R2";
            for (int loc = 0; loc < NLOC; loc++) frame(1, AW'(loc), 0, '0, 0, '1, 1);
            drain();
            // R4 R8: partial-lane writes, each read back in the next frame
            req = "R4 R8";
            for (int loc = 0; loc <= NLOC; loc++)
                frame(loc > 0, AW'(loc - 1), loc < NLOC, AW'(loc), 10 + mode,
                      8'(loc * 29 + 3), 0);
            drain();
            // R9: read and write to one location in the same frame
            req = "R9";
            frame(1, 4'd5, 1, 4'd5, 20 + mode, '1, 0);
            req = "R8";
            frame(1, 4'd5, 0, '0, 0, '1, 0);
            // R10: deselected frames with junk beats, then verify contents
            req = "R10";
            repeat (4) frame(0, '0, 0, 4'd7, 30, '1, 1);
            for (int loc = 0; loc < NLOC; loc++) frame(1, AW'(loc), 0, '0, 31, '1, 1);
            drain();
        end

        // R1: reset while a read is in flight discards it
        req = "R1";
        lat_long = 1'b1;
        frame(1, 4'd3, 0, '0, 0, '1, 0);
        do_reset();
        req = "R1 after reset";
        repeat (3) frame(0, '0, 0, '0, 0, '0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule